// File: doc/BRIEF.md
# Keyed Mode Register Write Guard

This block holds a mode control byte whose bit 0 turns a self-programming mode on or off, and shields it from stray stores caused by noise or runaway code. Software can change the byte only by following an unlock ritual on a simple write bus that has a strobe, an address and 8-bit data. The ritual has four writes. First the key 0xA5 goes to a command address. Then the wanted value goes to the control address, then the bitwise complement of that value, then the wanted value once more. Only the last of these four writes changes the byte. Any deviation leaves the byte as it was, drops the sequencer back to its locked state and raises a sticky protection-error flag.

A small status register sits beside the guard. It holds that protection-error flag and two error flags that are pulsed in by external hardware. Software clears each flag by writing 0 to its bit. The control byte and the status register can be read back through a combinational read port. The default addresses are 0x00 for the command register, 0x01 for the control register and 0x02 for the status register.

Top module: `keyed_mode_guard`

## Requirements
- R1: After reset the control byte is 0x00, mode_o is 0, the status register reads 0x00 and the sequencer is locked.
- R2: While locked, a write of 0xA5 to the command address (0x00) arms the sequencer. A write of any other value there leaves it locked and does not set the error flag.
- R3: The armed sequence is a control-address write of V, then of ~V, then of V. It loads V into the control byte on the fourth write, and V is readable and drives mode_o (bit 0) one cycle later. The second and third writes leave the byte unchanged.
- R4: A completed sequence uses up the unlock. A further control write needs a fresh key, or it is a violation.
- R5: A control-address write with no pending key leaves the byte unchanged and sets status bit 0.
- R6: A third write that is not the exact complement of the second, or a fourth write that differs from the second, sets status bit 0, leaves the byte unchanged and relocks the sequencer.
- R7: Any write to an address other than the control address while the sequencer is armed or mid-sequence is a violation. This covers a second key write and writes to the status address or to unmapped addresses. It sets status bit 0 and relocks.
- R8: A write to the status address (0x02) clears each of bits 0..2 whose data bit is 0. Bits whose data bit is 1 keep their value.
- R9: A pulse on hw_err_i[0] sets status bit 1 and a pulse on hw_err_i[1] sets status bit 2. A hardware or violation set wins over a software clear in the same cycle.
- R10: rd_data_o returns the control byte for address 0x01 and {5'b0, status} for address 0x02. It returns 0x00 for every other address, the write-only command address included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Write address |
| wdata_i | input | 8 | Write data |
| hw_err_i | input | 2 | Pulsed hardware error set inputs (status bits 1 and 2) |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data, combinational from register state |
| mode_o | output | 1 | Self-programming mode select, bit 0 of the control byte |

## Verification
Every write and every hardware error pulse is taken at one rising edge. Its effect on the control byte, the status bits, the sequencer state and mode_o shows up right after that edge, so each result is due one cycle after its stimulus. The bench drives each stimulus on a falling edge and advances its reference model at the following rising edge. It then compares rd_data_o and mode_o a short delay after that edge, with the read address held from the falling edge. A violation-free intermediate write is checked in the very cycle the byte would have changed, which catches a premature load.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    SEQ_LOCKED = 2'd0,
    SEQ_KEYED  = 2'd1,
    SEQ_VAL    = 2'd2,
    SEQ_INV    = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pw_unlock_fsm.sv
module pw_unlock_fsm
  import pw_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 8,
  parameter int unsigned          DATA_W    = 8,
  parameter logic [DATA_W-1:0]    KEY       = 8'hA5,
  parameter logic [ADDR_W-1:0]    CMD_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0]    CTRL_ADDR = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              viol_o
);
  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic [DATA_W-1:0] ctrl_q;
  logic              load;
  logic              hit_cmd, hit_ctrl;

  assign hit_cmd  = wr_i && (addr_i == CMD_ADDR);
  assign hit_ctrl = wr_i && (addr_i == CTRL_ADDR);

  always_comb begin
    state_d = state_q;
    val_d   = val_q;
    viol_o  = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      SEQ_LOCKED: begin
        if (hit_cmd && (wdata_i == KEY)) state_d = SEQ_KEYED;
        else if (hit_ctrl)               viol_o  = 1'b1;
      end
      SEQ_KEYED: begin
        if (hit_ctrl) begin
          val_d   = wdata_i;
          state_d = SEQ_VAL;
        end else if (wr_i) begin
          viol_o  = 1'b1;
          state_d = SEQ_LOCKED;
        end
      end
      SEQ_VAL: begin
        if (hit_ctrl && (wdata_i == ~val_q)) state_d = SEQ_INV;
        else if (wr_i) begin
          viol_o  = 1'b1;
          state_d = SEQ_LOCKED;
        end
      end
      SEQ_INV: begin
        if (wr_i) begin
          state_d = SEQ_LOCKED;
          if (hit_ctrl && (wdata_i == val_q)) load   = 1'b1;
          else                                viol_o = 1'b1;
        end
      end
      default: state_d = SEQ_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_LOCKED;
      val_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      val_q   <= val_d;
      if (load) ctrl_q <= val_q;
    end
  end

  assign ctrl_o = ctrl_q;

  assert_ctrl_only_final_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != $past(ctrl_q)) |-> $past(state_q == SEQ_INV && hit_ctrl));
  assert_key_arms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_LOCKED && hit_cmd && wdata_i == KEY) |=> (state_q == SEQ_KEYED));
  assert_nonkey_stays_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_LOCKED && hit_cmd && wdata_i != KEY) |=> (state_q == SEQ_LOCKED));
  assert_nokey_ctrl_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_LOCKED && hit_ctrl) |=> (ctrl_q == $past(ctrl_q)));
  assert_stray_addr_relocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_LOCKED && wr_i && !hit_ctrl) |=> (state_q == SEQ_LOCKED));
endmodule

// File: rtl/pw_status_reg.sv
module pw_status_reg #(
  parameter int unsigned       HW_N      = 2,
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h02,
  localparam int unsigned      STAT_W    = HW_N + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [STAT_W-1:0] wbits_i,
  input  logic              perr_set_i,
  input  logic [HW_N-1:0]   hw_err_i,
  output logic [STAT_W-1:0] stat_o
);
  logic              hit_stat;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] stat_q;

  assign hit_stat = wr_i && (addr_i == STAT_ADDR);
  assign set_vec  = {hw_err_i, perr_set_i};

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      stat_q[i] <= 1'b0;
      else if (set_vec[i])              stat_q[i] <= 1'b1;  // set beats clear
      else if (hit_stat && !wbits_i[i]) stat_q[i] <= 1'b0;
    end

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_vec[i] |=> stat_q[i]);
    assert_clear_by_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(stat_q[i]) |-> $past(hit_stat && !wbits_i[i]));
    assert_one_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_stat && wbits_i[i] && stat_q[i]) |=> stat_q[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/pw_read_mux.sv
module pw_read_mux #(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       STAT_W    = 3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h02
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] ctrl_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == CTRL_ADDR)      rd_data_o = ctrl_i;
    else if (rd_addr_i == STAT_ADDR) rd_data_o[STAT_W-1:0] = stat_i;
  end
endmodule

// File: rtl/keyed_mode_guard.sv
module keyed_mode_guard #(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 8,
  parameter int unsigned       HW_N      = 2,
  parameter logic [DATA_W-1:0] KEY       = 8'hA5,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h00,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h02
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [HW_N-1:0]   hw_err_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              mode_o
);
  localparam int unsigned STAT_W = HW_N + 1;

  logic [DATA_W-1:0] ctrl;
  logic [STAT_W-1:0] stat;
  logic              viol;

  pw_unlock_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY),
    .CMD_ADDR(CMD_ADDR), .CTRL_ADDR(CTRL_ADDR)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ctrl_o(ctrl), .viol_o(viol)
  );

  pw_status_reg #(
    .HW_N(HW_N), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)
  ) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wbits_i(wdata_i[STAT_W-1:0]), .perr_set_i(viol), .hw_err_i(hw_err_i),
    .stat_o(stat)
  );

  pw_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_rd (
    .rd_addr_i(rd_addr_i), .ctrl_i(ctrl), .stat_i(stat), .rd_data_o(rd_data_o)
  );

  assign mode_o = ctrl[0];

  assert_mode_tracks_ctrl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == CTRL_ADDR) |-> (rd_data_o[0] == mode_o));
endmodule

// File: tb/keyed_mode_guard_tb.sv
module keyed_mode_guard_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [1:0] hw_err_i = '0;
  logic [7:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  int m_ctrl = 0;
  int m_stat = 0;
  int m_step = 0;   // 0 idle, 1 key seen, 2 value seen, 3 inverse seen
  int m_val  = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  keyed_mode_guard u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .hw_err_i(hw_err_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .mode_o(mode_o)
  );

  function automatic int exp_rd(input int ra);
    if (ra == 1) return m_ctrl;
    if (ra == 2) return m_stat;
    return 0;
  endfunction

  task automatic compare(input string tag);
    int e;
    e = exp_rd(int'(rd_addr_i));
    n_chk++;
    if (int'(rd_data_o) != e) begin
      n_bad++;
      $display("FAIL %s rd_data addr=%0h actual=%0h expected=%0h", tag, rd_addr_i, rd_data_o, e);
    end
    n_chk++;
    if (int'(mode_o) != (m_ctrl & 1)) begin
      n_bad++;
      $display("FAIL %s mode_o actual=%0d expected=%0d", tag, mode_o, m_ctrl & 1);
    end
  endtask

  task automatic model(input bit w, input int a, input int d, input int he);
    bit v = 0;
    if (w) begin
      case (m_step)
        0: if (a == 0 && d == 'hA5) m_step = 1;
           else if (a == 1) v = 1;
        1: if (a == 1) begin m_val = d; m_step = 2; end
           else begin v = 1; m_step = 0; end
        2: if (a == 1 && d == (~m_val & 'hFF)) m_step = 3;
           else begin v = 1; m_step = 0; end
        default: begin
          if (a == 1 && d == m_val) m_ctrl = m_val;
          else v = 1;
          m_step = 0;
        end
      endcase
      if (a == 2) m_stat = m_stat & d & 7;
    end
    if (v) m_stat = m_stat | 1;
    if (he & 1) m_stat = m_stat | 2;
    if (he & 2) m_stat = m_stat | 4;
  endtask

  task automatic step(input bit w, input int a, input int d, input int he,
                      input int ra, input string tag);
    @(negedge clk_i);
    wr_i = w; addr_i = a[7:0]; wdata_i = d[7:0]; hw_err_i = he[1:0]; rd_addr_i = ra[7:0];
    @(posedge clk_i);
    model(w, a, d, he);
    #2;
    compare(tag);
    @(negedge clk_i);
    wr_i = 0; hw_err_i = 0;
  endtask

  task automatic wr(input int a, input int d, input int ra, input string tag);
    step(1, a, d, 0, ra, tag);
  endtask

  task automatic rd(input int ra, input string tag);
    step(0, 0, 0, 0, ra, tag);
  endtask

  task automatic unlock(input int v, input string tag);
    wr(0, 'hA5, 1, tag);
    wr(1, v, 1, tag);
    wr(1, ~v & 'hFF, 1, tag);
    wr(1, v, 1, tag);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    // R1 reset state
    rd(1, "R1"); rd(2, "R1");
    // R3 full sequence, intermediate writes leave byte
    unlock('h01, "R3");
    rd(2, "R3");
    // R4 unlock consumed
    wr(1, 'h00, 2, "R4");
    wr(1, 'hFF, 1, "R4");
    rd(2, "R4");
    // R8 writing ones keeps, zero clears
    wr(2, 'hFF, 2, "R8");
    wr(2, 'hFE, 2, "R8");
    // R2 non-key command write: no error, stays locked
    wr(0, 'h5A, 2, "R2");
    wr(1, 'h00, 2, "R2");
    wr(2, 'h00, 2, "R8");
    // R5 control write with no key
    wr(1, 'h42, 1, "R5");
    rd(2, "R5");
    wr(2, 'h00, 2, "R8");
    // R6 bad inverse
    wr(0, 'hA5, 1, "R6"); wr(1, 'h00, 1, "R6"); wr(1, 'hFE, 2, "R6");
    wr(1, 'hFF, 1, "R6");
    wr(2, 'h00, 2, "R6");
    // R6 bad repeat
    wr(0, 'hA5, 1, "R6"); wr(1, 'h00, 1, "R6"); wr(1, 'hFF, 1, "R6"); wr(1, 'h01, 2, "R6");
    rd(1, "R6");
    wr(2, 'h00, 2, "R6");
    // R7 unmapped address mid-sequence
    wr(0, 'hA5, 1, "R7"); wr(1, 'h00, 1, "R7"); wr('h10, 'h33, 2, "R7");
    wr(1, 'hFF, 1, "R7");
    wr(2, 'h00, 2, "R7");
    // R7 repeated key
    wr(0, 'hA5, 2, "R7"); wr(0, 'hA5, 2, "R7");
    wr(1, 'h80, 1, "R7");
    wr(2, 'h00, 2, "R7");
    // R7/R9 status write mid-sequence: violation set beats the clear
    wr(0, 'hA5, 2, "R7"); wr(1, 'h00, 2, "R7"); wr(1, 'hFF, 2, "R7");
    wr(2, 'h00, 2, "R9");
    wr(2, 'h00, 2, "R8");
    // R9 hardware error pulses
    step(0, 0, 0, 1, 2, "R9");
    step(0, 0, 0, 2, 2, "R9");
    step(1, 2, 'h00, 3, 2, "R9");
    wr(2, 'hF9, 2, "R8");
    wr(2, 'h00, 2, "R8");
    // R3 second full sequence, mode back off
    unlock('hAA, "R3");
    unlock('h37, "R3");
    // R10 readback of other addresses
    rd(0, "R10"); rd('h33, "R10"); rd(1, "R10");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule